// File: doc/BRIEF.md
# Shift and Rotate Execution Unit

This unit carries out the shift and rotate group of a legacy two-operand integer instruction set. One operation goes in per handshake: an operation code, a destination operand, a second source used only by the double-precision shifts, a count, the incoming carry and overflow flags, and an operand size of 8, 16 or 32 bits. One cycle later the unit presents the result together with new carry (CF) and overflow (OF) flags. These flags follow the legacy rules. A rotate through carry treats the carry as one more operand bit. A left shift flags overflow when the sign bit flips on the final step. A double shift fills the vacated bits from the second source.

Both sides are valid/ready streams. An operation is taken on a rising edge where `in_valid` and `in_ready` are both high. The single output register holds its contents, and `out_valid` stays high, until a rising edge where `out_ready` is high. `in_ready` is high whenever that register is empty or is being emptied in the same cycle, so a consumer that always accepts gives one operation per cycle. The count comes from one of two inputs: an immediate or a count register value. The unit only reads the count; it never writes it back.

Top module: `shift_rotate_unit`

## Requirements
- R1: `in_ready` is 1 when no result is held or `out_ready` is 1. While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_result`, `out_cf` and `out_of` keep their values into the next cycle. After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: An operation accepted on a clock edge appears on the outputs, with `out_valid` 1, directly after that edge.
- R3: The count is `in_cnt_reg` when `in_cnt_sel` is 1 and `in_cnt_imm` otherwise, and only its low 5 bits are used. A masked count of 0, or an operation code of 9 to 15, returns the sized destination with `out_cf` = `in_cf` and `out_of` = `in_of`.
- R4: `in_size` selects the operand width: 0 for 8 bits, 1 for 16 bits, and 2 or 3 for 32 bits. Operand bits above that width are ignored, and result bits above it are 0.
- R5: Code 2 is the left shift, whether arithmetic or logical. The result is the destination times 2^n with zero fill. CF is the last bit shifted out. OF is the result MSB XOR CF.
- R6: Code 1 is the logical right shift with zero fill. CF is the last bit shifted out. OF is the result MSB XOR the MSB held before the last step, which is the original MSB when n = 1 and 0 otherwise.
- R7: Code 0 is the arithmetic right shift. It fills with copies of the sign bit, giving floor(x / 2^n). CF is the last bit shifted out, and OF is 0.
- R8: Code 4 rotates left and code 3 rotates right, by n mod width; CF is not part of the rotation. CF becomes the result LSB after a left rotate and the result MSB after a right rotate. For n = 1, OF is result MSB XOR new CF after a left rotate and the XOR of the two top result bits after a right rotate; for other n, OF is 0.
- R9: Code 6 rotates left and code 5 rotates right through carry. The rotation covers the width+1 bits {CF, operand} by n mod (width+1), and CF takes the top bit of that extended value. OF follows the rules of R8.
- R10: Code 7 is the double left shift. It shifts the destination left by n and fills the low bits from the top of the second source; once the second source is used up, zeros come in. CF is the last destination bit shifted out. OF is the result MSB XOR CF.
- R11: Code 8 is the double right shift. It shifts the destination right by n and fills the high bits from the bottom of the second source, then zeros. CF is the last bit shifted out. OF is the result MSB XOR the MSB held before the last step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_op | input | 4 | Operation code (see R3 to R11) |
| in_size | input | 2 | Operand width select |
| in_dst | input | 32 | Destination operand |
| in_src | input | 32 | Second source for double shifts |
| in_cnt_imm | input | 8 | Immediate count |
| in_cnt_reg | input | 8 | Count register value |
| in_cnt_sel | input | 1 | 1 selects the count register value |
| in_cf | input | 1 | Incoming carry flag |
| in_of | input | 1 | Incoming overflow flag |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Result, zero above the operand width |
| out_cf | output | 1 | Outgoing carry flag |
| out_of | output | 1 | Outgoing overflow flag |

## Verification
Result and flags are due exactly one cycle after acceptance and stay put for as long as the consumer stalls. `in_ready` is combinational on `out_ready`. For that reason the bench drives every input just after a falling edge and waits 1 ns before it decides which handshakes the next rising edge will complete. It queues an expected record for each accepted operation. It compares and pops that record only in the cycle in which it also raises `out_ready` toward a held result. In the cycle after any acceptance, the bench checks that `out_valid` is high. In the cycle after any stall, it checks that the held values are unchanged.

// File: rtl/srx_pkg.sv
package srx_pkg;

  localparam int SRX_SHAMT_W = 5;

  typedef enum logic [3:0] {
    OP_SAR  = 4'd0,
    OP_SHR  = 4'd1,
    OP_SHL  = 4'd2,
    OP_ROR  = 4'd3,
    OP_ROL  = 4'd4,
    OP_RCR  = 4'd5,
    OP_RCL  = 4'd6,
    OP_SHLD = 4'd7,
    OP_SHRD = 4'd8
  } srx_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2
  } srx_size_e;

  function automatic logic srx_is_rotate(input srx_op_e op);
    return (op == OP_ROR) || (op == OP_ROL) || (op == OP_RCR) || (op == OP_RCL);
  endfunction

  function automatic logic srx_is_shift(input srx_op_e op);
    return (op == OP_SAR) || (op == OP_SHR) || (op == OP_SHL) ||
           (op == OP_SHLD) || (op == OP_SHRD);
  endfunction

endpackage

// File: rtl/srx_shifter.sv
module srx_shifter
  import srx_pkg::*;
#(
  parameter int W = 8
) (
  input  srx_op_e                op,
  input  logic [W-1:0]           dst,
  input  logic [W-1:0]           src,
  input  logic [SRX_SHAMT_W-1:0] cnt,
  output logic [W-1:0]           res,
  output logic                   cf,
  output logic                   of
);
  localparam int DW = 2 * W;

  // A second copy of each shifter runs one step behind, so the last bit
  // shifted out and the sign before the last step both come from it.
  logic [SRX_SHAMT_W-1:0] cnt_m1;
  logic [DW-1:0] lcat, lnow, lpre;
  logic [DW-1:0] rcat, rnow, rpre;
  logic [W-1:0]  snow, spre;

  assign cnt_m1 = cnt - 1'b1;

  always_comb begin
    lcat = {dst, (op == OP_SHLD) ? src : {W{1'b0}}};
    rcat = {(op == OP_SHRD) ? src : {W{1'b0}}, dst};
    lnow = lcat << cnt;
    lpre = lcat << cnt_m1;
    rnow = rcat >> cnt;
    rpre = rcat >> cnt_m1;
    snow = $signed(dst) >>> cnt;
    spre = $signed(dst) >>> cnt_m1;
    unique case (op)
      OP_SHL, OP_SHLD: begin
        res = lnow[DW-1:W];
        cf  = lpre[DW-1];
        of  = lnow[DW-1] ^ lpre[DW-1];
      end
      OP_SAR: begin
        res = snow;
        cf  = spre[0];
        of  = 1'b0;
      end
      default: begin
        res = rnow[W-1:0];
        cf  = rpre[0];
        of  = rnow[W-1] ^ rpre[W-1];
      end
    endcase
  end

endmodule

// File: rtl/srx_rotator.sv
module srx_rotator
  import srx_pkg::*;
#(
  parameter int W = 8
) (
  input  srx_op_e                op,
  input  logic [W-1:0]           dst,
  input  logic                   cf_in,
  input  logic [SRX_SHAMT_W-1:0] cnt,
  output logic [W-1:0]           res,
  output logic                   cf,
  output logic                   of
);
  localparam int EW = W + 1;

  logic [SRX_SHAMT_W-1:0] amt_plain, amt_ext;
  logic [2*W-1:0]  pdup, pl, pr;
  logic [2*EW-1:0] edup, el, er;
  logic            one_step;

  assign amt_plain = SRX_SHAMT_W'(32'(cnt) % W);
  assign amt_ext   = SRX_SHAMT_W'(32'(cnt) % EW);
  assign one_step  = (cnt == SRX_SHAMT_W'(1));

  always_comb begin
    pdup = {dst, dst};
    edup = {cf_in, dst, cf_in, dst};
    pl   = pdup << amt_plain;
    pr   = pdup >> amt_plain;
    el   = edup << amt_ext;
    er   = edup >> amt_ext;
    res  = dst;
    cf   = cf_in;
    unique case (op)
      OP_ROL: begin
        res = pl[2*W-1:W];
        cf  = pl[W];
      end
      OP_ROR: begin
        res = pr[W-1:0];
        cf  = pr[W-1];
      end
      OP_RCL: {cf, res} = el[2*EW-1:EW];
      default: {cf, res} = er[EW-1:0];
    endcase
    if (!one_step)
      of = 1'b0;
    else if ((op == OP_ROL) || (op == OP_RCL))
      of = res[W-1] ^ cf;
    else
      of = res[W-1] ^ res[W-2];
  end

endmodule

// File: rtl/srx_lane.sv
module srx_lane
  import srx_pkg::*;
#(
  parameter int W = 8
) (
  input  srx_op_e                op,
  input  logic [W-1:0]           dst,
  input  logic [W-1:0]           src,
  input  logic                   cf_in,
  input  logic                   of_in,
  input  logic [SRX_SHAMT_W-1:0] cnt,
  output logic [W-1:0]           res,
  output logic                   cf,
  output logic                   of
);
  logic [W-1:0] sh_res, ro_res;
  logic         sh_cf, sh_of, ro_cf, ro_of;

  srx_shifter #(.W(W)) u_shift (
    .op (op),
    .dst(dst),
    .src(src),
    .cnt(cnt),
    .res(sh_res),
    .cf (sh_cf),
    .of (sh_of)
  );

  srx_rotator #(.W(W)) u_rot (
    .op   (op),
    .dst  (dst),
    .cf_in(cf_in),
    .cnt  (cnt),
    .res  (ro_res),
    .cf   (ro_cf),
    .of   (ro_of)
  );

  always_comb begin
    res = dst;
    cf  = cf_in;
    of  = of_in;
    if (cnt != '0) begin
      if (srx_is_shift(op)) begin
        res = sh_res;
        cf  = sh_cf;
        of  = sh_of;
      end else if (srx_is_rotate(op)) begin
        res = ro_res;
        cf  = ro_cf;
        of  = ro_of;
      end
    end
  end

endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import srx_pkg::*;
#(
  parameter int BASE_W    = 8,
  parameter int NUM_LANES = 3,
  parameter int CNT_W     = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [3:0]  in_op,
  input  logic [1:0]  in_size,
  input  logic [31:0] in_dst,
  input  logic [31:0] in_src,
  input  logic [7:0]  in_cnt_imm,
  input  logic [7:0]  in_cnt_reg,
  input  logic        in_cnt_sel,
  input  logic        in_cf,
  input  logic        in_of,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_result,
  output logic        out_cf,
  output logic        out_of
);
  localparam int DATA_W = BASE_W << (NUM_LANES - 1);
  localparam int SEL_W  = $clog2(NUM_LANES);

  srx_op_e                op;
  logic [CNT_W-1:0]       cnt_raw;
  logic [SRX_SHAMT_W-1:0] cnt_eff;
  logic [SEL_W-1:0]       lane_sel;
  logic [DATA_W-1:0]      lane_res [NUM_LANES];
  logic [NUM_LANES-1:0]   lane_cf, lane_of;
  logic                   accept;

  logic [DATA_W-1:0] res_q;
  logic              cf_q, of_q, vld_q;
  logic [1:0]        size_q;

  assign op       = srx_op_e'(in_op);
  assign cnt_raw  = in_cnt_sel ? in_cnt_reg : in_cnt_imm;
  assign cnt_eff  = cnt_raw[SRX_SHAMT_W-1:0];
  assign lane_sel = (32'(in_size) >= NUM_LANES) ? SEL_W'(NUM_LANES - 1) : SEL_W'(in_size);

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int LW = BASE_W << g;
    logic [LW-1:0] l_res;
    srx_lane #(.W(LW)) u_lane (
      .op   (op),
      .dst  (in_dst[LW-1:0]),
      .src  (in_src[LW-1:0]),
      .cf_in(in_cf),
      .of_in(in_of),
      .cnt  (cnt_eff),
      .res  (l_res),
      .cf   (lane_cf[g]),
      .of   (lane_of[g])
    );
    assign lane_res[g] = DATA_W'(l_res);
  end

  assign in_ready = !vld_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      res_q  <= '0;
      cf_q   <= 1'b0;
      of_q   <= 1'b0;
      size_q <= 2'd0;
    end else if (accept) begin
      vld_q  <= 1'b1;
      res_q  <= lane_res[lane_sel];
      cf_q   <= lane_cf[lane_sel];
      of_q   <= lane_of[lane_sel];
      size_q <= in_size;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid  = vld_q;
  assign out_result = res_q;
  assign out_cf     = cf_q;
  assign out_of     = of_q;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_cf) && $stable(out_of)); // R1

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R2

  AST_ZERO_COUNT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (cnt_eff == '0) && in_size[1]
    |=> (out_result == $past(in_dst)) && (out_cf == $past(in_cf)) && (out_of == $past(in_of))); // R3

  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (size_q == 2'(SZ_BYTE)) |-> (out_result[DATA_W-1:BASE_W] == '0)); // R4

  AST_SAR_OF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (op == OP_SAR) && (cnt_eff != '0) |=> !out_of); // R7

  AST_ROT_OF_MULTI: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && srx_is_rotate(op) && (cnt_eff > SRX_SHAMT_W'(1)) |=> !out_of); // R8

endmodule

// File: tb/test_shift_rotate_unit.sv
`timescale 1ns/1ps
module test_shift_rotate_unit;

  localparam int PER_PASS = 10 * 4 * 32;
  localparam int TOTAL    = 2 * PER_PASS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [1:0]  in_size = '0;
  logic [31:0] in_dst = '0, in_src = '0;
  logic [7:0]  in_cnt_imm = '0, in_cnt_reg = '0;
  logic        in_cnt_sel = 1'b0, in_cf = 1'b0, in_of = 1'b0;
  logic        out_valid, out_ready = 1'b0;
  logic [31:0] out_result;
  logic        out_cf, out_of;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [31:0] res;
    logic        cf;
    logic        of;
    logic [31:0] mask;
    string       tag;
  } exp_t;

  exp_t q[$];

  always #4 clk = ~clk;

  shift_rotate_unit i_shift_rotate_unit (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op), .in_size(in_size),
    .in_dst(in_dst), .in_src(in_src), .in_cnt_imm(in_cnt_imm), .in_cnt_reg(in_cnt_reg),
    .in_cnt_sel(in_cnt_sel), .in_cf(in_cf), .in_of(in_of),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_cf(out_cf), .out_of(out_of)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int op, input int c);
    if (c == 0 || op > 8) return "R3";
    case (op)
      0: return "R7";
      1: return "R6";
      2: return "R5";
      3, 4: return "R8";
      5, 6: return "R9";
      7: return "R10";
      default: return "R11";
    endcase
  endfunction

  // Step-by-step reference: one bit per iteration, flags from the final steps.
  function automatic exp_t model(input int op, input int size, input logic [31:0] dst,
                                 input logic [31:0] src, input int c, input logic cf, input logic of);
    exp_t e;
    int w = (size == 0) ? 8 : (size == 1) ? 16 : 32;
    logic [31:0] mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    logic [31:0] d = dst & mask;
    logic [31:0] s = src & mask;
    logic rc = cf, ro = of, premsb = 1'b0, b;
    if (c != 0 && op <= 8) begin
      for (int k = 0; k < c; k++) begin
        premsb = d[w-1];
        case (op)
          0: begin rc = d[0]; d = (d >> 1) | (32'(premsb) << (w-1)); end
          1: begin rc = d[0]; d = d >> 1; end
          2: begin rc = d[w-1]; d = (d << 1) & mask; end
          3: begin b = d[0]; d = (d >> 1) | (32'(b) << (w-1)); rc = b; end
          4: begin b = d[w-1]; d = ((d << 1) | 32'(b)) & mask; rc = b; end
          5: begin b = d[0]; d = (d >> 1) | (32'(rc) << (w-1)); rc = b; end
          6: begin b = d[w-1]; d = ((d << 1) | 32'(rc)) & mask; rc = b; end
          7: begin rc = d[w-1]; d = ((d << 1) | 32'(s[w-1])) & mask; s = (s << 1) & mask; end
          default: begin rc = d[0]; d = (d >> 1) | (32'(s[0]) << (w-1)); s = s >> 1; end
        endcase
      end
      if (op == 0) ro = 1'b0;
      else if (op >= 3 && op <= 6) begin
        if (c != 1) ro = 1'b0;
        else if (op == 4 || op == 6) ro = d[w-1] ^ rc;
        else ro = d[w-1] ^ d[w-2];
      end else ro = d[w-1] ^ premsb;
    end
    e.res = d; e.cf = rc; e.of = ro; e.mask = mask; e.tag = tag_of(op, c);
    return e;
  endfunction

  task automatic load_item(input int idx);
    int pass = idx / PER_PASS;
    int rem  = idx % PER_PASS;
    int opi  = rem / 128;
    int c    = rem % 32;
    logic [7:0] cnt8 = 8'(c) | 8'(($urandom % 8) << 5);
    in_op   = (opi < 9) ? 4'(opi) : 4'(9 + $urandom % 7);
    in_size = 2'((rem / 32) % 4);
    if (pass == 0) begin
      in_dst = $urandom;
      in_src = $urandom;
    end else begin
      case (c % 4)
        0: in_dst = 32'h8080_8080;
        1: in_dst = 32'h7F7F_7F7F;
        2: in_dst = 32'hFFFF_FFFF;
        default: in_dst = 32'h0000_0001;
      endcase
      in_src = ~in_dst;
    end
    in_cnt_sel = 1'($urandom);
    if (in_cnt_sel) begin in_cnt_reg = cnt8; in_cnt_imm = 8'($urandom); end
    else begin in_cnt_imm = cnt8; in_cnt_reg = 8'($urandom); end
    in_cf = 1'($urandom);
    in_of = 1'($urandom);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int sent = 0;
    bit acc_prev = 1'b0, held_prev = 1'b0;
    logic [31:0] h_res;
    logic h_cf, h_of, h_vld;
    exp_t e;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "out_valid in reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "out_valid after reset", 32'(out_valid), 32'd0);
    check("R1", "in_ready after reset", 32'(in_ready), 32'd1);
    while (!(sent == TOTAL && q.size() == 0 && !out_valid)) begin
      @(negedge clk);
      if (held_prev) begin
        h_vld = out_valid;
        check("R1", "stall valid", 32'(h_vld), 32'd1);
        check("R1", "stall result", out_result, h_res);
        check("R1", "stall flags", {30'd0, out_cf, out_of}, {30'd0, h_cf, h_of});
      end
      if (acc_prev) check("R2", "valid after accept", 32'(out_valid), 32'd1);
      if (!in_valid || acc_prev) begin
        if (sent < TOTAL) begin load_item(sent); in_valid = 1'b1; end
        else in_valid = 1'b0;
      end
      out_ready = ($urandom % 4) != 0;
      #1;
      acc_prev = in_valid && in_ready;
      if (acc_prev) begin
        q.push_back(model(int'(in_op), int'(in_size), in_dst, in_src,
                          int'(in_cnt_sel ? in_cnt_reg[4:0] : in_cnt_imm[4:0]), in_cf, in_of));
        sent++;
      end
      if (out_valid && out_ready) begin
        if (q.size() == 0) check("R2", "unexpected output", 32'd1, 32'd0);
        else begin
          e = q.pop_front();
          check(e.tag, "result", out_result, e.res);
          check(e.tag, "carry", 32'(out_cf), 32'(e.cf));
          check(e.tag, "overflow", 32'(out_of), 32'(e.of));
          check("R4", "bits above width", out_result & ~e.mask, 32'd0);
        end
      end
      held_prev = out_valid && !out_ready;
      h_res = out_result; h_cf = out_cf; h_of = out_of;
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule